// File: doc/BRIEF.md
# Transceiver Charge Pump Sleep Controller

This block decides when the charge pump and line drivers of a two-channel RS-232 interface can be switched off to save power, and when they must come back on. While automatic sleep is enabled and the UART core is awake, the controller watches the transmit path, the receive-data and clear-to-send levels, transmit-holding-register writes and edges on the other serial inputs. Once all of them have been quiet for a programmable number of clock cycles, it removes the pump enable and puts the drivers in high impedance. Line receivers and register access are not affected.

A rising edge on receive data, clear-to-send or any general-purpose serial input, a transmit-register write, or clearing the enable pin restarts the pump. The drivers are released, and readiness is flagged, only after a programmable recovery interval. A separate full-sleep state covers the case where the UART core has already stopped its oscillator. Both counter lengths are parameters in clock cycles. Asynchronous pins pass through two-stage synchronizers.

Top module: `pump_sleep_ctrl`

## Requirements
- R1: In reset the pump is enabled, the drivers are enabled (`drv_hiz_o` = 0), `pump_rdy_o` = 1 and `full_sleep_o` = 0.
- R2: No automatic shutdown happens while the synchronized enable pin is low or while `uart_asleep_i` is high, however long the inputs stay quiet.
- R3: With the controller ready and everything quiet, the pump switches off on the IDLE_CYCLES+1-th clock edge. Quiet means `tx_active_i` low, synchronized receive data and clear-to-send low, no write strobe and no serial-input edge. `drv_hiz_o` then goes to 1 and `pump_rdy_o` to 0.
- R4: Any qualifying activity restarts the idle count from zero. This includes a high level on `tx_active_i`, a write strobe, or an edge of either polarity on any serial input, and holds even on the last cycle of the count.
- R5: A rising edge on `rxd_i` while the pump is off enables the pump on the third clock edge after the pin changes (two synchronizer stages plus edge detection).
- R6: A write strobe `thr_wr_i` while the pump is off enables the pump on the next clock edge.
- R7: A rising edge on `cts_i` or on any bit of `gpi_i` while the pump is off enables the pump on the third clock edge. A falling edge on these inputs leaves the pump off.
- R8: After every wake the pump stays enabled with drivers in high impedance for exactly WAKE_CYCLES clock cycles. `pump_rdy_o` then rises and the drivers are enabled.
- R9: A low level on the synchronized enable pin while the pump is off starts a wake. The pump is enabled on the third edge after the pin falls.
- R10: When the synchronized enable pin is high, `uart_asleep_i` is high and `osc_run_i` is low, full sleep is entered on the next edge from any state. In full sleep `full_sleep_o` = 1, the pump is off, the drivers are in high impedance and `pump_rdy_o` = 0.
- R11: Full sleep is left for the wake sequence of R8 on the next edge after `osc_run_i` goes high, or on the third edge after the enable pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| autosleep_i | input | 1 | Asynchronous pin enabling automatic pump sleep |
| uart_asleep_i | input | 1 | UART core sleep flag (synchronous) |
| osc_run_i | input | 1 | Oscillator running status (synchronous) |
| tx_active_i | input | 1 | Transmit output activity (synchronous) |
| rxd_i | input | 1 | Receive-data line level (asynchronous) |
| cts_i | input | 1 | Clear-to-send level (asynchronous) |
| thr_wr_i | input | 1 | One-cycle transmit holding register or FIFO write strobe |
| gpi_i | input | GP_W | Other handshake and general-purpose serial inputs (asynchronous) |
| pump_en_o | output | 1 | Charge pump enable |
| drv_hiz_o | output | 1 | Line drivers in high impedance when 1 |
| pump_rdy_o | output | 1 | Pump recovered and drivers usable |
| full_sleep_o | output | 1 | Pump and oscillator both asleep |

## Verification
The bench sweeps the restart point of the idle count over every cycle of the window, including the final cycle. A design that checks the timeout before it checks activity would turn the pump off there despite a write. It also measures the exact latency of each wake source through the synchronizers, and it injects falling edges while asleep. A design that woke on any change would switch on at that point. Full-sleep entry is exercised from the running, sleeping and recovering states, and both exits are tried. A design without the priority of full sleep, or one that skipped the recovery interval after leaving full sleep, would show the wrong state or a ready flag that comes too early.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    ST_ON   = 2'd0,
    ST_OFF  = 2'd1,
    ST_WAKE = 2'd2,
    ST_FULL = 2'd3
  } pump_state_e;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pss_edge.sv
module pss_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] any_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign rise_o[g] = d_i[g] & ~prev_q[g];
    assign any_o[g]  = d_i[g] ^ prev_q[g];
  end
endmodule

// File: rtl/pss_idle_timer.sv
module pss_idle_timer #(
  parameter int IDLE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic act_i,
  output logic idle_done_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!arm_i || act_i)   cnt_q <= '0;
    else if (cnt_q != LIMIT)    cnt_q <= cnt_q + CW'(1);
  end

  assign idle_done_o = (cnt_q == LIMIT);

  p_act_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> !idle_done_o);
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
#(
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_i,
  input  logic uart_asleep_i,
  input  logic osc_run_i,
  input  logic arm_i,
  input  logic idle_done_i,
  input  logic act_i,
  input  logic wake_i,
  input  logic thr_wr_i,
  output logic pump_en_o,
  output logic drv_hiz_o,
  output logic on_o,
  output logic full_o
);
  localparam int RW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [RW-1:0] LAST = RW'(WAKE_CYCLES - 1);

  pump_state_e state_q, state_d;
  logic [RW-1:0] rcnt_q;
  logic full_go;

  assign full_go = auto_i && uart_asleep_i && !osc_run_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ON: begin
        if (full_go)                              state_d = ST_FULL;
        else if (arm_i && idle_done_i && !act_i)  state_d = ST_OFF;
      end
      ST_OFF: begin
        if (full_go)                              state_d = ST_FULL;
        else if (!auto_i || wake_i)               state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (full_go)                              state_d = ST_FULL;
        else if (rcnt_q == LAST)                  state_d = ST_ON;
      end
      ST_FULL: begin
        if (!auto_i || osc_run_i)                 state_d = ST_WAKE;
      end
      default:                                    state_d = ST_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ON;
      rcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_WAKE) rcnt_q <= '0;
      else                    rcnt_q <= rcnt_q + RW'(1);
    end
  end

  assign pump_en_o = (state_q == ST_ON) || (state_q == ST_WAKE);
  assign on_o      = (state_q == ST_ON);
  assign drv_hiz_o = (state_q != ST_ON);
  assign full_o    = (state_q == ST_FULL);

  p_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && !arm_i) |=> state_q != ST_OFF);
  p_idle_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && !idle_done_i) |=> state_q != ST_OFF);
  p_thr_wake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && thr_wr_i && !full_go) |=> state_q == ST_WAKE);
  p_rdy_delay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE && rcnt_q != LAST) |=> state_q != ST_ON);
  p_auto_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && !auto_i) |=> state_q == ST_WAKE);
  p_full_entry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_go |=> state_q == ST_FULL);
  p_full_exit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FULL && (!auto_i || osc_run_i)) |=> state_q == ST_WAKE);
endmodule

// File: rtl/pump_sleep_ctrl.sv
module pump_sleep_ctrl #(
  parameter int GP_W        = 4,
  parameter int IDLE_CYCLES = 1105920000,
  parameter int WAKE_CYCLES = 1659
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            autosleep_i,
  input  logic            uart_asleep_i,
  input  logic            osc_run_i,
  input  logic            tx_active_i,
  input  logic            rxd_i,
  input  logic            cts_i,
  input  logic            thr_wr_i,
  input  logic [GP_W-1:0] gpi_i,
  output logic            pump_en_o,
  output logic            drv_hiz_o,
  output logic            pump_rdy_o,
  output logic            full_sleep_o
);
  localparam int LW = GP_W + 2;  // rxd, cts, gpi
  localparam int SW = LW + 1;    // plus autosleep pin

  logic [SW-1:0] pins_s;
  logic [LW-1:0] line_s, line_rise, line_any;
  logic auto_s, rxd_s, cts_s;
  logic act, wake, arm, idle_done, on;

  pss_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({autosleep_i, gpi_i, cts_i, rxd_i}),
    .q_o   (pins_s)
  );

  assign line_s = pins_s[LW-1:0];
  assign auto_s = pins_s[SW-1];
  assign rxd_s  = line_s[0];
  assign cts_s  = line_s[1];

  pss_edge #(.W(LW)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_s),
    .rise_o(line_rise),
    .any_o (line_any)
  );

  assign act  = tx_active_i | rxd_s | cts_s | thr_wr_i | (|line_any);
  assign wake = thr_wr_i | (|line_rise);
  assign arm  = on && auto_s && !uart_asleep_i;

  pss_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .act_i      (act),
    .idle_done_o(idle_done)
  );

  pss_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .auto_i       (auto_s),
    .uart_asleep_i(uart_asleep_i),
    .osc_run_i    (osc_run_i),
    .arm_i        (arm),
    .idle_done_i  (idle_done),
    .act_i        (act),
    .wake_i       (wake),
    .thr_wr_i     (thr_wr_i),
    .pump_en_o    (pump_en_o),
    .drv_hiz_o    (drv_hiz_o),
    .on_o         (on),
    .full_o       (full_sleep_o)
  );

  assign pump_rdy_o = on;
endmodule

// File: tb/pump_sleep_ctrl_test.sv
module pump_sleep_ctrl_test;
  localparam int GP_W = 3;
  localparam int IDLE = 12;
  localparam int WAKE = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic autosleep, uart_asleep, osc_run, tx_active, rxd, cts, thr_wr;
  logic [GP_W-1:0] gpi;
  logic pump_en, drv_hiz, pump_rdy, full_sleep;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pump_sleep_ctrl #(.GP_W(GP_W), .IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .autosleep_i(autosleep),
    .uart_asleep_i(uart_asleep), .osc_run_i(osc_run), .tx_active_i(tx_active),
    .rxd_i(rxd), .cts_i(cts), .thr_wr_i(thr_wr), .gpi_i(gpi),
    .pump_en_o(pump_en), .drv_hiz_o(drv_hiz), .pump_rdy_o(pump_rdy),
    .full_sleep_o(full_sleep)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return pump_en;
      1: return pump_rdy;
      default: return full_sleep;
    endcase
  endfunction

  // edges until output sel reaches val
  task automatic wait_for(input int sel, input logic val, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (sig(sel) !== val && n < 300);
  endtask

  task automatic pulse_thr();
    thr_wr = 1'b1;
    step();
    thr_wr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; autosleep = 1'b1; uart_asleep = 1'b0; osc_run = 1'b1;
    tx_active = 1'b1; rxd = 1'b0; cts = 1'b0; thr_wr = 1'b0; gpi = '0;
    repeat (3) step();
    chk("R1 pump_en", pump_en, 1);
    chk("R1 drv_hiz", drv_hiz, 0);
    chk("R1 pump_rdy", pump_rdy, 1);
    chk("R1 full_sleep", full_sleep, 0);
    rst_n = 1'b1;

    // R2: enable pin low blocks shutdown
    autosleep = 1'b0;
    repeat (4) step();
    tx_active = 1'b0;
    repeat (IDLE + 8) step();
    chk("R2 pin low keeps pump", pump_en, 1);
    // R2: UART asleep with oscillator running blocks shutdown and full sleep
    autosleep = 1'b1; uart_asleep = 1'b1;
    repeat (IDLE + 8) step();
    chk("R2 uart asleep keeps pump", pump_en, 1);
    chk("R10 no full sleep with osc running", full_sleep, 0);
    uart_asleep = 1'b0;
    wait_for(0, 1'b0, n);
    chk("R3 idle latency", n, IDLE + 1);
    chk("R3 drivers hiz", drv_hiz, 1);
    chk("R3 not ready", pump_rdy, 0);

    // R4/R6/R8 sweep of restart point across the whole window
    for (int k = 1; k <= IDLE; k++) begin
      tx_active = 1'b1;
      pulse_thr();
      chk("R6 write wakes", pump_en, 1);
      wait_for(1, 1'b1, n);
      chk("R8 recovery length", n, WAKE);
      tx_active = 1'b0;
      repeat (k) step();
      chk("R4 still on before restart", pump_en, 1);
      pulse_thr();
      wait_for(0, 1'b0, n);
      chk("R4 restart by write", n, IDLE + 1);
    end

    // R4: serial input edges of both polarities restart the count
    tx_active = 1'b1;
    pulse_thr();
    wait_for(1, 1'b1, n);
    tx_active = 1'b0;
    repeat (IDLE - 2) step();
    gpi[1] = 1'b1;
    wait_for(0, 1'b0, n);
    chk("R4 restart by rising gpi", n, IDLE + 4);
    // R7: falling edge while off is ignored
    gpi[1] = 1'b0;
    repeat (8) step();
    chk("R7 falling gpi ignored", pump_en, 0);
    tx_active = 1'b1;
    pulse_thr();
    wait_for(1, 1'b1, n);
    gpi[1] = 1'b1;
    repeat (4) step();
    tx_active = 1'b0;
    repeat (IDLE - 2) step();
    gpi[1] = 1'b0;
    wait_for(0, 1'b0, n);
    chk("R4 restart by falling gpi", n, IDLE + 4);

    // R7: rising gpi wakes
    gpi[2] = 1'b1;
    wait_for(0, 1'b1, n);
    chk("R7 gpi wake latency", n, 3);
    wait_for(1, 1'b1, n);
    chk("R8 recovery after gpi", n, WAKE);
    wait_for(0, 1'b0, n);
    chk("R3 idle after gpi wake", n, IDLE + 1);

    // R7: rising cts wakes; cts level keeps pump on
    cts = 1'b1;
    wait_for(0, 1'b1, n);
    chk("R7 cts wake latency", n, 3);
    wait_for(1, 1'b1, n);
    repeat (IDLE + 4) step();
    chk("R3 cts high keeps pump", pump_en, 1);
    cts = 1'b0;
    wait_for(0, 1'b0, n);
    chk("R3 idle after cts low", n, IDLE + 4);

    // R5: rising rxd wakes
    rxd = 1'b1;
    wait_for(0, 1'b1, n);
    chk("R5 rxd wake latency", n, 3);
    wait_for(1, 1'b1, n);
    rxd = 1'b0;
    wait_for(0, 1'b0, n);
    chk("R3 idle after rxd low", n, IDLE + 4);

    // R9: enable pin low while off
    autosleep = 1'b0;
    wait_for(0, 1'b1, n);
    chk("R9 pin low wake latency", n, 3);
    wait_for(1, 1'b1, n);
    chk("R8 recovery after pin low", n, WAKE);
    autosleep = 1'b1;
    repeat (3) step();

    // R10/R11: full sleep from running state, exit by oscillator
    uart_asleep = 1'b1; osc_run = 1'b0;
    step();
    chk("R10 full entry from on", full_sleep, 1);
    chk("R10 pump off", pump_en, 0);
    chk("R10 drivers hiz", drv_hiz, 1);
    chk("R10 not ready", pump_rdy, 0);
    repeat (10) step();
    chk("R10 full held", full_sleep, 1);
    osc_run = 1'b1;
    step();
    chk("R11 osc exit", full_sleep, 0);
    chk("R11 pump on", pump_en, 1);
    wait_for(1, 1'b1, n);
    chk("R8 recovery after full", n, WAKE);

    // R10 from off, R11 exit by pin low, R10 from recovery
    uart_asleep = 1'b0;
    wait_for(0, 1'b0, n);
    chk("R3 idle before full", n, IDLE + 1);
    uart_asleep = 1'b1; osc_run = 1'b0;
    step();
    chk("R10 full entry from off", full_sleep, 1);
    autosleep = 1'b0;
    wait_for(2, 1'b0, n);
    chk("R11 pin low exit latency", n, 3);
    chk("R11 pump on after pin exit", pump_en, 1);
    chk("R11 not ready yet", pump_rdy, 0);
    autosleep = 1'b1;
    repeat (3) step();
    chk("R10 full entry from recovery", full_sleep, 1);
    osc_run = 1'b1;
    step();
    chk("R11 final exit", full_sleep, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule